// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O bank. Software drives it through a small word-addressed register bus: one strobe for reads, one for writes, a byte address, write data and read data. Each pin can be made an output, in which case its output data bit is driven onto the pad. When a pin is an input, its level is read back through a two-stage synchronizer.

Every pin also has its own event detector. Three independent configuration bits select how the detector works: level or edge sensing, an override that reacts to both edges, and the active polarity. A detected event sets a sticky raw status bit. Software clears a status bit by writing a one to it in a clear register. A per-pin enable masks the raw status. The masked status can be read back as its own register. A single interrupt line goes high whenever any masked status bit is set.

The register bus is a control path. It is not a data stream, so it has no back-pressure. A write takes effect on the clock edge where it is sampled. Read data appears one cycle after the read strobe is sampled.

Top module: `gpio_bank_irq`

## Requirements
- R1: After reset every register reads 0, `pad_oe` and `pad_out` are all zeros, and `irq` is 0.
- R2: The output data (0x04), output enable (0x08), level select (0x0C), both-edge select (0x10), polarity (0x14) and interrupt enable (0x18) registers read back the last value written. `pad_out` equals the output data register and `pad_oe` equals the output enable register. Bit n of every per-pin register belongs to pin n.
- R3: The input register (0x00) returns `pad_in` delayed by two synchronizer flops. A read sampled one or two edges after a pad change returns the old value. A read sampled on the third edge returns the new value.
- R4: With level select 0, both-edge select 0 and polarity 1, a 0-to-1 transition of the synchronized pin sets its raw status bit (0x1C). A 1-to-0 transition does not.
- R5: With level select 0, both-edge select 0 and polarity 0, a 1-to-0 transition sets the raw status bit. A 0-to-1 transition does not.
- R6: With level select 0 and both-edge select 1, both transitions set the raw status bit, whatever the polarity bit holds.
- R7: With level select 1, the raw status bit is set on every cycle the synchronized pin equals its polarity bit (1 = high active, 0 = low active). A clear therefore does not stick while that level persists.
- R8: Writing the clear register (0x24) clears each raw status bit written as 1. Bits written as 0 keep their value. The clear register reads as 0.
- R9: When a pin's detector fires in the same cycle that a clear of that pin is written, the status bit ends up set.
- R10: The masked status register (0x20) reads as raw status AND interrupt enable.
- R11: `irq` is a flop that goes high one cycle after any masked status bit is set, and goes low one cycle after none is set.
- R12: Writes to the input, raw status and masked status addresses have no effect on any register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 6 | Byte address; bits [1:0] must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| pad_in | input | 32 | Asynchronous pad input levels |
| pad_out | output | 32 | Pad output data |
| pad_oe | output | 32 | Pad output enable, 1 = drive |
| irq | output | 1 | Combined interrupt request |

## Verification
The hardest case to reach from the ports is a detector firing on the exact clock edge where a clear write to the same pin is sampled. The bench reaches it by counting the synchronizer and history flops from the pad change, then placing the clear write on the third edge after that change. A level-sensitive pin held active gives a second route to the same collision. The pad change, clear write and read are all issued on falling edges, so the relative timing is fixed.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  // Word index of each register (byte address / 4).
  typedef enum logic [3:0] {
    GR_DIN  = 4'd0,
    GR_DOUT = 4'd1,
    GR_OE   = 4'd2,
    GR_LVL  = 4'd3,
    GR_BOTH = 4'd4,
    GR_POL  = 4'd5,
    GR_EN   = 4'd6,
    GR_RAW  = 4'd7,
    GR_MSK  = 4'd8,
    GR_CLR  = 4'd9
  } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q_now,
  output logic [W-1:0] q_prev
);
  logic [W-1:0] chain [STAGES];

  for (genvar k = 0; k < STAGES; k++) begin : g_stg
    if (k == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) chain[k] <= '0;
        else        chain[k] <= d;
      end
    end else begin : g_rest
      always_ff @(posedge clk) begin
        if (!rst_n) chain[k] <= '0;
        else        chain[k] <= chain[k-1];
      end
    end
  end

  // History flop used by the edge detectors.
  always_ff @(posedge clk) begin
    if (!rst_n) q_prev <= '0;
    else        q_prev <= chain[STAGES-1];
  end

  assign q_now = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] cur,
  input  logic [NPIN-1:0] prev,
  input  logic [NPIN-1:0] lvl_sel,
  input  logic [NPIN-1:0] both_sel,
  input  logic [NPIN-1:0] pol_sel,
  input  logic [NPIN-1:0] clr_mask,
  output logic [NPIN-1:0] status
);
  logic [NPIN-1:0] hit;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic rise, fall;
    assign rise = cur[i] & ~prev[i];
    assign fall = ~cur[i] & prev[i];
    always_comb begin
      if (lvl_sel[i])       hit[i] = (cur[i] == pol_sel[i]);
      else if (both_sel[i]) hit[i] = rise | fall;
      else                  hit[i] = pol_sel[i] ? rise : fall;
    end
  end

  // A new event wins over a clear sampled on the same edge.
  always_ff @(posedge clk) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_mask) | hit;
  end

  // R8: a cleared bit with no new event is low on the next cycle
  a_r8_clear_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & $past(clr_mask) & ~$past(hit)) == '0));
  // R9: any event leaves its status bit set, a clear notwithstanding
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((~status & $past(hit)) == '0));
  // R6: both-edge pins react to any change of the synchronized input
  a_r6_both_edges: assert property (@(posedge clk) disable iff (!rst_n)
    ((~lvl_sel & both_sel & (cur ^ prev)) != '0)
    |=> ((status & $past(~lvl_sel & both_sel & (cur ^ prev)))
         == $past(~lvl_sel & both_sel & (cur ^ prev))));
  // R7: level pins at their active level are set on the next cycle
  a_r7_level_active: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl_sel & ~(cur ^ pol_sel)) != '0)
    |=> ((status & $past(lvl_sel & ~(cur ^ pol_sel)))
         == $past(lvl_sel & ~(cur ^ pol_sel))));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int NPIN   = 32,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   din,
  input  logic [NPIN-1:0]   raw,
  output logic [NPIN-1:0]   dout,
  output logic [NPIN-1:0]   oe,
  output logic [NPIN-1:0]   lvl_sel,
  output logic [NPIN-1:0]   both_sel,
  output logic [NPIN-1:0]   pol_sel,
  output logic [NPIN-1:0]   irq_en,
  output logic [NPIN-1:0]   clr_mask
);
  localparam int IW = ADDR_W - 2;

  logic          word_ok;
  logic [IW-1:0] widx;
  logic          wr_hit;
  logic [NPIN-1:0] rd_mux;

  assign word_ok = (bus_addr[1:0] == 2'b00);
  assign widx    = bus_addr[ADDR_W-1:2];
  assign wr_hit  = bus_wr && word_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dout     <= '0;
      oe       <= '0;
      lvl_sel  <= '0;
      both_sel <= '0;
      pol_sel  <= '0;
      irq_en   <= '0;
    end else if (wr_hit) begin
      if (widx == IW'(GR_DOUT)) dout     <= bus_wdata;
      if (widx == IW'(GR_OE))   oe       <= bus_wdata;
      if (widx == IW'(GR_LVL))  lvl_sel  <= bus_wdata;
      if (widx == IW'(GR_BOTH)) both_sel <= bus_wdata;
      if (widx == IW'(GR_POL))  pol_sel  <= bus_wdata;
      if (widx == IW'(GR_EN))   irq_en   <= bus_wdata;
    end
  end

  assign clr_mask = (wr_hit && widx == IW'(GR_CLR)) ? bus_wdata : '0;

  always_comb begin
    rd_mux = '0;
    if (word_ok) begin
      case (widx)
        IW'(GR_DIN):  rd_mux = din;
        IW'(GR_DOUT): rd_mux = dout;
        IW'(GR_OE):   rd_mux = oe;
        IW'(GR_LVL):  rd_mux = lvl_sel;
        IW'(GR_BOTH): rd_mux = both_sel;
        IW'(GR_POL):  rd_mux = pol_sel;
        IW'(GR_EN):   rd_mux = irq_en;
        IW'(GR_RAW):  rd_mux = raw;
        IW'(GR_MSK):  rd_mux = raw & irq_en;
        default:      rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq #(
  parameter int NPIN        = 32,
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPIN-1:0]   bus_wdata,
  output logic [NPIN-1:0]   bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe,
  output logic              irq
);
  logic [NPIN-1:0] s_cur, s_prev;
  logic [NPIN-1:0] lvl_sel, both_sel, pol_sel, irq_en, clr_mask;
  logic [NPIN-1:0] raw;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q_now(s_cur), .q_prev(s_prev)
  );

  gpio_regs #(.NPIN(NPIN), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .din(s_cur), .raw(raw), .dout(pad_out), .oe(pad_oe),
    .lvl_sel(lvl_sel), .both_sel(both_sel), .pol_sel(pol_sel),
    .irq_en(irq_en), .clr_mask(clr_mask)
  );

  gpio_irq_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .cur(s_cur), .prev(s_prev),
    .lvl_sel(lvl_sel), .both_sel(both_sel), .pol_sel(pol_sel),
    .clr_mask(clr_mask), .status(raw)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(raw & irq_en);
  end

  // R11: irq only rises after an enabled status bit was set
  a_r11_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((raw & irq_en) != '0));
  // R11: irq drops only after the last enabled status bit went away
  a_r11_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past((raw & irq_en) == '0));
endmodule

// File: tb/gpio_bank_irq_tb.sv
module gpio_bank_irq_tb;
  localparam logic [5:0] A_DIN = 6'h00, A_DOUT = 6'h04, A_OE = 6'h08,
    A_LVL = 6'h0C, A_BOTH = 6'h10, A_POL = 6'h14, A_EN = 6'h18,
    A_RAW = 6'h1C, A_MSK = 6'h20, A_CLR = 6'h24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, pad_in = '0, pad_out, pad_oe;
  logic irq;

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  gpio_bank_irq u_dut (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // All driver tasks are entered on a falling edge and return on the next one.
  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
    exp_q.push_back(exp);
    tag_q.push_back(req);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: a read sampled on a rising edge is compared on the next falling edge.
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (exp_q.size() == 0) chk("MON", bus_rdata, 32'hx);
        else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 0);
    chk("R1 pad_out", pad_out, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    for (int a = 0; a < 10; a++) rd(6'(a * 4), 0, "R1 reg");

    // R2 output path and readback
    wr(A_DOUT, 32'hA5A5_0F0F);
    wr(A_OE, 32'hFFFF_0000);
    chk("R2 pad_out", pad_out, 32'hA5A5_0F0F);
    chk("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    rd(A_DOUT, 32'hA5A5_0F0F, "R2 dout");
    rd(A_OE, 32'hFFFF_0000, "R2 oe");

    // R3 synchronizer latency
    pad_in = 32'hCAFE_0001;
    rd(A_DIN, 0, "R3 edge1");
    rd(A_DIN, 0, "R3 edge2");
    rd(A_DIN, 32'hCAFE_0001, "R3 edge3");

    // Setup: pin0 rising, pin1 falling, pin2 both, pin3 high level, pin4 low level
    pad_in = 32'h10;
    idle(4);
    wr(A_POL, 32'h9);
    wr(A_BOTH, 32'h4);
    wr(A_LVL, 32'h18);
    wr(A_CLR, 32'hFFFF_FFFF);
    idle(2);
    rd(A_RAW, 0, "R8 clear all");
    rd(A_POL, 32'h9, "R2 pol");
    rd(A_BOTH, 32'h4, "R2 both");
    rd(A_LVL, 32'h18, "R2 lvl");

    pad_in = 32'h13; idle(4);
    rd(A_RAW, 32'h1, "R4 rise only pin0");
    pad_in = 32'h10; idle(4);
    rd(A_RAW, 32'h3, "R5 fall pin1");
    wr(A_CLR, 32'h1);
    rd(A_RAW, 32'h2, "R8 partial clear");
    wr(A_CLR, 32'hFFFF_FFFF);

    pad_in = 32'h14; idle(4);
    rd(A_RAW, 32'h4, "R6 both rise");
    wr(A_CLR, 32'h4);
    rd(A_RAW, 0, "R6 cleared");
    pad_in = 32'h10; idle(4);
    rd(A_RAW, 32'h4, "R6 both fall");
    wr(A_CLR, 32'hFFFF_FFFF);

    pad_in = 32'h18; idle(4);
    rd(A_RAW, 32'h8, "R7 high level");
    wr(A_CLR, 32'h8);
    rd(A_RAW, 32'h8, "R7 reassert");
    pad_in = 32'h08; idle(4);
    rd(A_RAW, 32'h18, "R7 low level");
    pad_in = 32'h00; idle(4);
    wr(A_CLR, 32'h8);
    rd(A_RAW, 32'h10, "R7 inactive clears");

    // R9 edge and clear on the same edge
    pad_in = 32'h10; idle(4);
    wr(A_CLR, 32'hFFFF_FFFF);
    rd(A_RAW, 0, "R9 pre");
    pad_in = 32'h11;
    idle(2);
    wr(A_CLR, 32'h1);
    rd(A_RAW, 32'h1, "R9 set wins");

    // R10 / R11 masking and interrupt line
    rd(A_MSK, 0, "R10 masked off");
    chk("R11 irq masked", {31'b0, irq}, 0);
    wr(A_EN, 32'h1);
    chk("R11 irq latency", {31'b0, irq}, 0);
    idle(1);
    chk("R11 irq high", {31'b0, irq}, 1);
    rd(A_MSK, 32'h1, "R10 masked on");
    wr(A_EN, 32'h2);
    rd(A_MSK, 0, "R10 other pin");
    idle(1);
    chk("R11 irq low", {31'b0, irq}, 0);
    wr(A_EN, 32'h3);

    // R12 read-only addresses ignore writes
    wr(A_DIN, 32'hFFFF_FFFF);
    rd(A_DIN, 32'h11, "R12 din");
    wr(A_RAW, 32'h0);
    rd(A_RAW, 32'h1, "R12 raw");
    wr(A_MSK, 32'h0);
    rd(A_MSK, 32'h1, "R12 msk");
    rd(A_CLR, 0, "R8 clr reads zero");
    rd(A_EN, 32'h3, "R2 en");

    idle(3);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule